// File: doc/BRIEF.md
# Carrier Interrupt Status Controller

This block sits inside a four-slot carrier bridge and gathers the interrupt requests of the plug-in modules into a single host interrupt. Each slot drives two request lines. Each slot also has an 8-bit control register. That register turns each line on or off and selects whether the line is edge or level sensitive. A 16-bit status register shows the captured state of every enabled line and a per-slot timeout flag. A read-only revision register is also present. Software reaches all of them over a simple 16-bit register bus. Reads on this bus are combinational and writes take effect at the clock edge.

A line's status bit follows the line only while the line's enable bit is set. When an enabled line changes a status bit and that line is edge-configured, the host output is inverted for exactly one cycle and then returns to its held value. The held value is the OR of all status bits whose lines are level-configured. Lines are serviced through single-cycle clear-request outputs toward the slots. A write of one to a status interrupt bit raises such a request. So does an acknowledge read on the interrupt-space port, but only for a level-configured line whose status bit is set. Timeout flags are set by an external event input and cleared by writing one to them.

Top module: `carrier_irq_ctrl`

## Requirements
- R1: Reset clears every control register, the status register, the clear-request outputs and the host interrupt. The revision register at offset 0x00 always reads 0x0000.
- R2: Slot s (0..3) has its control register at byte offset 2*(s+1), which gives 0x02, 0x04, 0x06 and 0x08. A write stores bits 7:0 of the write data. A read returns the stored byte in bits 7:0 and zero in bits 15:8.
- R3: Line n (0 or 1) of slot s maps to status bit 2*s+n. While control bit 6+n of that slot is set, the status bit takes the line's value at each rising clock edge. The status register is read at offset 0x0C.
- R4: While control bit 6+n is clear, the status bit for that line holds its value whatever the line does.
- R5: Control bit 4+n set makes the line edge-configured. A status change on such a line drives the host interrupt to the inverse of its held value for the one cycle after the capturing edge. The host interrupt then returns to the held value.
- R6: The held host level is 1 exactly when some status bit whose line has control bit 4+n clear is set. It appears on the host interrupt in the cycle after the capturing edge.
- R7: Status bits 12+s are slot timeout flags. A pulse on tmo_evt[s] sets flag s. Writing 1 to bit 12+s at offset 0x0C clears it. A set in the same cycle wins over the clear.
- R8: Writing 1 to status bit k (k in 7:0) pulses slot_clr[k] for the one cycle after the write, and leaves the status bit to follow its line. Status bits 11:8 always read 0 and ignore writes.
- R9: An acknowledge read with ack_off 0 or 2 targets line 0 or 1 of slot ack_slot. It pulses slot_clr for that line in the next cycle only if the status bit is set and the line is level-configured. Any other ack_off has no effect.
- R10: Offsets 0x0A, 0x0E and every other unmapped offset read as 0x0000. Writes to them change no register.
- R11: When no enabled line differs from its status bit, the host interrupt keeps its level and does not pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational, zero when no read is selected |
| slot_irq | input | 8 | Request lines, bit 2*s+n is slot s line n |
| slot_clr | output | 8 | One-cycle clear requests toward the slot lines |
| tmo_evt | input | 4 | Timeout event pulses, one per slot |
| ack_rd | input | 1 | Acknowledge read strobe on the interrupt-space port |
| ack_slot | input | 2 | Slot addressed by the acknowledge |
| ack_off | input | 6 | Offset in the slot's interrupt space |
| host_irq | output | 1 | Host interrupt output |

## Verification
The bench builds the block with its default parameters: four slots, eight request lines, an 8-bit offset and a 16-bit data word. At these values every status field is in use: all eight interrupt bits, the four timeout flags at 15:12 and the zero error field at 11:8. With four slots the bench can mix edge and level lines in one run. It covers a pulse that dips an asserted host level, a pulse that rises from a quiet level, and a pulse and a level change landing on the same edge.

// File: rtl/carrier_irq_pkg.sv
package carrier_irq_pkg;
    // Register word and control byte sizes
    localparam int REG_W          = 16;
    localparam int CTRL_W         = 8;
    // Control byte layout: per-line edge select and enable
    localparam int EDGE_SEL_LSB   = 4;
    localparam int LINE_EN_LSB    = 6;
    // Status word layout
    localparam int ERR_LSB        = 8;
    localparam int ERR_W          = 4;
    localparam int TMO_LSB        = 12;
    // Offsets: control registers start at 2 with a stride of 2
    localparam int CTRL_OFF_BASE  = 2;
    localparam int CTRL_OFF_STEP  = 2;
    localparam int STATUS_OFF     = 12;
    // Acknowledge offsets in a slot's interrupt space: line n at 2*n
    localparam int ACK_OFF_STEP   = 2;

    typedef enum logic [1:0] {
        HI_QUIET     = 2'd0,
        HI_RAISED    = 2'd1,
        HI_BLIP_UP   = 2'd2,
        HI_BLIP_DOWN = 2'd3
    } host_state_t;
endpackage

// File: rtl/cic_ctrl_file.sv
module cic_ctrl_file
    import carrier_irq_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int ADDR_W    = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [ADDR_W-1:0]                   addr,
    input  logic [CTRL_W-1:0]                   wdata,
    output logic [NUM_SLOTS-1:0][CTRL_W-1:0]    ctrl_q
);

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        localparam logic [ADDR_W-1:0] MY_OFF = ADDR_W'(CTRL_OFF_BASE + CTRL_OFF_STEP * s);
        logic hit;
        assign hit = wr_en && (addr == MY_OFF);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ctrl_q[s] <= '0;
            end else if (hit) begin
                ctrl_q[s] <= wdata;
            end
        end

        AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && (addr == MY_OFF)) |=> $stable(ctrl_q[s])); // R10
    end

endmodule

// File: rtl/cic_status_bank.sv
module cic_status_bank
    import carrier_irq_pkg::*;
#(
    parameter  int NUM_SLOTS = 4,
    localparam int NL        = 2 * NUM_SLOTS,
    localparam int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NL-1:0]     line_in,
    input  logic [NL-1:0]     line_en,
    input  logic [NL-1:0]     line_edge,
    input  logic [NUM_SLOTS-1:0] tmo_evt,
    input  logic              st_wr,
    input  logic [REG_W-1:0]  st_wdata,
    input  logic              ack_rd,
    input  logic [SLOT_W-1:0] ack_slot,
    input  logic [5:0]        ack_off,
    output logic [REG_W-1:0]  status,
    output logic [NL-1:0]     line_clr,
    output logic              edge_evt,
    output logic              lvl_next
);

    logic [NL-1:0]        int_q, int_d, chg, ack_hit, w1c_int;
    logic [NUM_SLOTS-1:0] tmo_q, tmo_d, w1c_tmo;

    // Capture: an enabled line that differs from its status bit flips it
    assign chg      = line_en & (line_in ^ int_q);
    assign int_d    = int_q ^ chg;
    assign edge_evt = |(chg & line_edge);
    assign lvl_next = |(int_d & ~line_edge);

    assign w1c_int  = st_wr ? st_wdata[NL-1:0] : '0;
    assign w1c_tmo  = st_wr ? st_wdata[TMO_LSB +: NUM_SLOTS] : '0;
    assign tmo_d    = (tmo_q & ~w1c_tmo) | tmo_evt;

    // Acknowledge decode: one hit per line, level lines with status set only
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_ack_slot
        for (genvar n = 0; n < 2; n++) begin : g_ack_line
            localparam int K = 2 * s + n;
            assign ack_hit[K] = ack_rd
                             && (ack_slot == SLOT_W'(s))
                             && (ack_off == 6'(ACK_OFF_STEP * n))
                             && int_q[K]
                             && !line_edge[K];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_q    <= '0;
            tmo_q    <= '0;
            line_clr <= '0;
        end else begin
            int_q    <= int_d;
            tmo_q    <= tmo_d;
            line_clr <= w1c_int | ack_hit;
        end
    end

    // Error field stays zero; only interrupt and timeout fields are live
    always_comb begin
        status = '0;
        status[NL-1:0] = int_q;
        status[TMO_LSB +: NUM_SLOTS] = tmo_q;
    end

    for (genvar k = 0; k < NL; k++) begin : g_line_chk
        AST_LINE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
            !line_en[k] |=> $stable(status[k])); // R4
        AST_CLR_NEEDS_SET: assert property (@(posedge clk) disable iff (!rst_n)
            (!st_wr && !status[k]) |=> !line_clr[k]); // R9
        AST_ACK_EDGE_NO_CLR: assert property (@(posedge clk) disable iff (!rst_n)
            (!st_wr && line_edge[k]) |=> !line_clr[k]); // R9
    end

    for (genvar t = 0; t < NUM_SLOTS; t++) begin : g_tmo_chk
        AST_TMO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (st_wr && st_wdata[TMO_LSB + t] && !tmo_evt[t]) |=> !status[TMO_LSB + t]); // R7
        AST_TMO_SET: assert property (@(posedge clk) disable iff (!rst_n)
            tmo_evt[t] |=> status[TMO_LSB + t]); // R7
    end

    AST_ERR_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && (st_wdata[ERR_LSB +: ERR_W] != '0)) |=> (status[ERR_LSB +: ERR_W] == '0)); // R8

endmodule

// File: rtl/cic_host_irq_fsm.sv
module cic_host_irq_fsm
    import carrier_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic edge_evt,
    input  logic lvl_next,
    output logic host_irq
);

    host_state_t state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HI_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: an edge event forces a one-cycle blip opposite to the
    // level that will be held; otherwise the held level is tracked.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HI_QUIET, HI_RAISED, HI_BLIP_UP, HI_BLIP_DOWN: begin
                if (edge_evt) begin
                    state_d = lvl_next ? HI_BLIP_DOWN : HI_BLIP_UP;
                end else begin
                    state_d = lvl_next ? HI_RAISED : HI_QUIET;
                end
            end
        endcase
    end

    // Outputs
    always_comb begin
        host_irq = 1'b0;
        unique case (state_q)
            HI_QUIET:     host_irq = 1'b0;
            HI_RAISED:    host_irq = 1'b1;
            HI_BLIP_UP:   host_irq = 1'b1;
            HI_BLIP_DOWN: host_irq = 1'b0;
        endcase
    end

    AST_EDGE_INVERTS: assert property (@(posedge clk) disable iff (!rst_n)
        edge_evt |=> (host_irq != $past(lvl_next))); // R5
    AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_evt |=> (host_irq == $past(lvl_next))); // R6
    AST_BLIP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == HI_BLIP_UP || state_q == HI_BLIP_DOWN) && !edge_evt)
        |=> (state_q == HI_QUIET || state_q == HI_RAISED)); // R5
    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_evt && $past(!edge_evt) && (lvl_next == $past(lvl_next))) |=> $stable(host_irq)); // R11

endmodule

// File: rtl/carrier_irq_ctrl.sv
module carrier_irq_ctrl
    import carrier_irq_pkg::*;
#(
    parameter  int NUM_SLOTS = 4,
    parameter  int ADDR_W    = 8,
    localparam int NL        = 2 * NUM_SLOTS,
    localparam int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_sel,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    input  logic [NL-1:0]        slot_irq,
    output logic [NL-1:0]        slot_clr,
    input  logic [NUM_SLOTS-1:0] tmo_evt,
    input  logic                 ack_rd,
    input  logic [SLOT_W-1:0]    ack_slot,
    input  logic [5:0]           ack_off,
    output logic                 host_irq
);

    localparam logic [ADDR_W-1:0] STAT_OFF = ADDR_W'(STATUS_OFF);

    logic [NUM_SLOTS-1:0][CTRL_W-1:0] ctrl_q;
    logic [NL-1:0]    line_en, line_edge;
    logic [REG_W-1:0] status, rd_mux;
    logic             st_wr, edge_evt, lvl_next, addr_mapped;

    assign st_wr = reg_sel && reg_wr && (reg_addr == STAT_OFF);

    cic_ctrl_file #(
        .NUM_SLOTS (NUM_SLOTS),
        .ADDR_W    (ADDR_W)
    ) ctrl_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_sel && reg_wr),
        .addr   (reg_addr),
        .wdata  (reg_wdata[CTRL_W-1:0]),
        .ctrl_q (ctrl_q)
    );

    // Per-line enable and edge-select taken from the owning slot's byte
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_cfg
        for (genvar n = 0; n < 2; n++) begin : g_line
            assign line_en[2*s+n]   = ctrl_q[s][LINE_EN_LSB + n];
            assign line_edge[2*s+n] = ctrl_q[s][EDGE_SEL_LSB + n];
        end
    end

    cic_status_bank #(
        .NUM_SLOTS (NUM_SLOTS)
    ) stat_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_in   (slot_irq),
        .line_en   (line_en),
        .line_edge (line_edge),
        .tmo_evt   (tmo_evt),
        .st_wr     (st_wr),
        .st_wdata  (reg_wdata),
        .ack_rd    (ack_rd),
        .ack_slot  (ack_slot),
        .ack_off   (ack_off),
        .status    (status),
        .line_clr  (slot_clr),
        .edge_evt  (edge_evt),
        .lvl_next  (lvl_next)
    );

    cic_host_irq_fsm fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .edge_evt (edge_evt),
        .lvl_next (lvl_next),
        .host_irq (host_irq)
    );

    // Read path: revision (0x00), reset (0x0A) and unmapped offsets give zero
    always_comb begin
        rd_mux = '0;
        addr_mapped = 1'b0;
        if (reg_addr == STAT_OFF) begin
            rd_mux = status;
            addr_mapped = 1'b1;
        end
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (reg_addr == ADDR_W'(CTRL_OFF_BASE + CTRL_OFF_STEP * s)) begin
                rd_mux = {{(REG_W-CTRL_W){1'b0}}, ctrl_q[s]};
                addr_mapped = 1'b1;
            end
        end
    end

    assign reg_rdata = (reg_sel && !reg_wr) ? rd_mux : '0;

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && !reg_wr && !addr_mapped) |-> (reg_rdata == '0)); // R10
    AST_CTRL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && !reg_wr && addr_mapped && reg_addr != STAT_OFF)
        |-> (reg_rdata[REG_W-1:CTRL_W] == '0)); // R2

endmodule

// File: tb/carrier_irq_ctrl_tb_top.sv
module carrier_irq_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0, reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0, reg_rdata;
    logic [7:0]  slot_irq = '0, slot_clr;
    logic [3:0]  tmo_evt = '0;
    logic        ack_rd = 1'b0;
    logic [1:0]  ack_slot = '0;
    logic [5:0]  ack_off = '0;
    logic        host_irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    carrier_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .slot_irq(slot_irq), .slot_clr(slot_clr), .tmo_evt(tmo_evt),
        .ack_rd(ack_rd), .ack_slot(ack_slot), .ack_off(ack_off),
        .host_irq(host_irq)
    );

    // {wr, addr, wdata, expected read}
    localparam int NVEC = 14;
    localparam logic [40:0] VEC [NVEC] = '{
        {1'b1, 8'h02, 16'hABC5, 16'h0000},  // R2 write slot 0
        {1'b0, 8'h02, 16'h0000, 16'h00C5},  // R2 upper byte dropped
        {1'b1, 8'h04, 16'h0033, 16'h0000},
        {1'b0, 8'h04, 16'h0000, 16'h0033},
        {1'b1, 8'h06, 16'h0011, 16'h0000},
        {1'b0, 8'h06, 16'h0000, 16'h0011},
        {1'b1, 8'h08, 16'h00F0, 16'h0000},
        {1'b0, 8'h08, 16'h0000, 16'h00F0},
        {1'b1, 8'h00, 16'hFFFF, 16'h0000},  // R10 revision ignores writes
        {1'b0, 8'h00, 16'h0000, 16'h0000},
        {1'b1, 8'h0A, 16'h1234, 16'h0000},  // R10 reset offset
        {1'b0, 8'h0A, 16'h0000, 16'h0000},
        {1'b0, 8'h03, 16'h0000, 16'h0000},  // R10 odd offset
        {1'b0, 8'h02, 16'h0000, 16'h00C5}   // R10 slot 0 untouched
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
        #1;
        v = reg_rdata;
        reg_sel = 1'b0;
    endtask

    task automatic drive_lines(input logic [7:0] v);
        @(negedge clk);
        slot_irq = v;
        @(negedge clk);
    endtask

    task automatic ack(input logic [1:0] s, input logic [5:0] o);
        @(negedge clk);
        ack_rd = 1'b1; ack_slot = s; ack_off = o;
        @(negedge clk);
        ack_rd = 1'b0;
    endtask

    task automatic tmo_pulse(input logic [3:0] v);
        @(negedge clk);
        tmo_evt = v;
        @(negedge clk);
        tmo_evt = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 host_irq in reset", {15'd0, host_irq}, 16'h0000);
        chk("R1 slot_clr in reset", {8'd0, slot_clr}, 16'h0000);
        rst_n = 1'b1;
        reg_read(8'h0C, v); chk("R1 status after reset", v, 16'h0000);
        reg_read(8'h08, v); chk("R1 ctrl after reset", v, 16'h0000);

        // Register vector table
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][40]) begin
                reg_write(VEC[i][39:32], VEC[i][31:16]);
            end else begin
                reg_read(VEC[i][39:32], v);
                chk($sformatf("R2_R10 table entry %0d", i), v, VEC[i][15:0]);
            end
        end
        for (int s = 0; s < 4; s++) reg_write(8'(2 * (s + 1)), 16'h0000);

        // R5: slot 0 line 0 enabled, edge-configured; rise gives one-cycle blip
        reg_write(8'h02, 16'h0050);
        drive_lines(8'h01);
        chk("R5 blip up", {15'd0, host_irq}, 16'h0001);
        @(negedge clk);
        chk("R5 blip ends", {15'd0, host_irq}, 16'h0000);
        reg_read(8'h0C, v); chk("R3 status bit0", v, 16'h0001);

        // R11: line held, no change, no action
        repeat (3) @(negedge clk);
        chk("R11 host quiet", {15'd0, host_irq}, 16'h0000);

        // R4: slot 2 disabled, its line 0 (bit 4) ignored
        drive_lines(8'h11);
        @(negedge clk);
        chk("R4 host unchanged", {15'd0, host_irq}, 16'h0000);
        reg_read(8'h0C, v); chk("R4 status bit4 held", v, 16'h0001);

        // R6: slot 1 line 1 (bit 3) enabled, level
        reg_write(8'h04, 16'h0080);
        drive_lines(8'h19);
        chk("R6 host raised", {15'd0, host_irq}, 16'h0001);
        reg_read(8'h0C, v); chk("R3 status bits 0,3", v, 16'h0009);

        // R5: edge event while level high dips the output for one cycle
        drive_lines(8'h18);
        chk("R5 blip down", {15'd0, host_irq}, 16'h0000);
        @(negedge clk);
        chk("R5 back to level", {15'd0, host_irq}, 16'h0001);

        // R9 acknowledge reads
        ack(2'd1, 6'd2);
        chk("R9 ack level line", {8'd0, slot_clr}, 16'h0008);
        @(negedge clk);
        chk("R9 clr one cycle", {8'd0, slot_clr}, 16'h0000);
        ack(2'd1, 6'd0);
        chk("R9 ack clear bit", {8'd0, slot_clr}, 16'h0000);
        ack(2'd1, 6'd4);
        chk("R9 ack bad offset", {8'd0, slot_clr}, 16'h0000);
        drive_lines(8'h19);
        chk("R5 second blip down", {15'd0, host_irq}, 16'h0000);
        ack(2'd0, 6'd0);
        chk("R9 ack edge line", {8'd0, slot_clr}, 16'h0000);

        // R8 write-one clear requests, error bits ignored
        reg_write(8'h0C, 16'h0F09);
        chk("R8 clear request", {8'd0, slot_clr}, 16'h0009);
        @(negedge clk);
        chk("R8 clear one cycle", {8'd0, slot_clr}, 16'h0000);
        reg_read(8'h0C, v); chk("R8 status unchanged", v, 16'h0009);
        drive_lines(8'h00);
        chk("R5 blip up on fall", {15'd0, host_irq}, 16'h0001);
        @(negedge clk);
        chk("R6 host low", {15'd0, host_irq}, 16'h0000);
        reg_read(8'h0C, v); chk("R3 status cleared", v, 16'h0000);

        // R7 timeout flags
        tmo_pulse(4'h4);
        reg_read(8'h0C, v); chk("R7 timeout set", v, 16'h4000);
        tmo_pulse(4'h1);
        reg_write(8'h0C, 16'h4000);
        reg_read(8'h0C, v); chk("R7 w1c one flag", v, 16'h1000);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = 8'h0C; reg_wdata = 16'h1000; tmo_evt = 4'h1;
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b0; tmo_evt = '0;
        reg_read(8'h0C, v); chk("R7 set wins", v, 16'h1000);
        reg_write(8'h0C, 16'h1000);
        reg_read(8'h0C, v); chk("R7 cleared", v, 16'h0000);

        // R1 reset mid-run
        drive_lines(8'h08);
        chk("R6 host before reset", {15'd0, host_irq}, 16'h0001);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1 host cleared", {15'd0, host_irq}, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;
        reg_read(8'h04, v); chk("R1 ctrl cleared", v, 16'h0000);
        reg_read(8'h0C, v); chk("R1 status cleared", v, 16'h0000);
        chk("R1 host stays low", {15'd0, host_irq}, 16'h0000);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule